// File: doc/BRIEF.md
# Programmable Serial Audio Frame Serializer

This block turns a stream of stereo sample pairs into a three-wire serial audio signal: a bit clock, a left/right select line and a serial data line. It runs from a master clock. The bit clock is that clock divided by a programmable integer. Each half of a frame lasts a programmable number of bit clocks. The layout inside each half is set by control inputs: the number of sample bits sent, their order, an optional one-bit delay after the select edge, and an optional codec control word for each half. The control word is taken from a 32-bit control input.

Samples enter through a valid/ready handshake into a single holding slot. `in_ready` is high exactly when the slot is empty. A sample accepted there waits until the next frame begins, and the frame that begins consumes it. Back-pressure is therefore paced by the frame rate: after one handshake, `in_ready` stays low until the following frame start frees the slot. If a frame begins while the slot is empty, the previous pair is sent again and a sticky underrun flag is raised. Lowering `en` stops the serial lines, clears that flag and re-arms the framer, so the next frame starts cleanly on the left channel. The layout inputs may only change while `en` is low.

Top module: `aud_frame_ser`

## Requirements
- R1: While `en` is high, `bclk` is periodic with a period of `bclk_div`+1 master clock cycles. `bclk_div` must be at least 1.
- R2: A frame lasts 2×(`lr_div`+1) bit clocks, which allows up to 512. `lrclk` is 0 for the first `lr_div`+1 bits (left channel) and 1 for the rest (right channel).
- R3: `sdata` and `lrclk` change only together with a falling edge of `bclk`, so they are stable while `bclk` is high and at each rising edge.
- R4: Each half sends `nbits_m1`+1 sample bits. These are the upper bits of the 16-bit sample. With `lsb_first`=0 they go most significant first (half position q carries bit 15−q). With `lsb_first`=1 the least significant retained bit goes first.
- R5: With `i2s_dly`=1 the sample bits start one bit clock after the `lrclk` change (half position 1). With `i2s_dly`=0 they start at half position 0.
- R6: If `ctl_en[0]` is set (left) or `ctl_en[1]` is set (right), that half carries a control word of `ctl_len_m1`+1 bits starting at half position `ctl_pos`, sent most significant first. The word is the low bits of `ctl_word[15:0]` for the left half and of `ctl_word[31:16]` for the right half. Sample bits take priority where the two overlap. All other positions send 0.
- R7: `in_ready` is high exactly when the holding slot is empty, and it falls in the cycle after a handshake. Accepted pairs are sent in order, one per frame, starting with the next frame start.
- R8: A frame that starts with an empty slot resends the previous pair and sets `underrun`. The flag stays set while `en` is high and clears in the cycle after `en` is seen low.
- R9: While `en` is low, `bclk`, `lrclk` and `sdata` are 0. The first bit after `en` rises is position 0 of a left half.
- R10: After reset, `bclk`, `lrclk`, `sdata` and `underrun` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops and re-arms the framer |
| bclk_div | input | 7 | Bit clock divider minus one |
| lr_div | input | 8 | Bits per channel half minus one |
| lsb_first | input | 1 | 1: least significant retained bit first |
| nbits_m1 | input | 4 | Sample bits per channel minus one |
| i2s_dly | input | 1 | 1: sample bits start one bit after the select edge |
| ctl_word | input | 32 | Control words: [15:0] left half, [31:16] right half |
| ctl_en | input | 2 | Control word enable per half: [0] left, [1] right |
| ctl_pos | input | 8 | Half position of the first control bit |
| ctl_len_m1 | input | 4 | Control word length minus one |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding slot empty |
| in_left | input | 16 | Left sample |
| in_right | input | 16 | Right sample |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Channel select, 0 = left |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a frame started without a new pair |

## Verification
The bench targets the bit-order and width edges: a single-bit channel, twelve bits sent LSB first, and full sixteen-bit MSB-first words with the one-bit delay. A wrong index or an off-by-one delay shifts or reverses these bits and shows up as data mismatches. A control word placed so that it overlaps the sample field checks the priority rule. A longest 512-bit frame with a control word only on the right half catches a position counter that wraps early or a half enable that is decoded the wrong way. A starvation phase checks that the last pair is repeated, that the flag stays set after data resumes and that it clears on disable. An odd divider checks the period, and a design that mistimed the bit clock or let data move while it was high would fail the period and sampling checks.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;
  // Channel carried in the current half frame; value equals the select line
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/aud_bclk_gen.sv
module aud_bclk_gen #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick,   // bit boundary: bclk falls at this edge
  output logic             bclk
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] rise_at;

  assign rise_at = DIV_W'(({1'b0, div} + 1'b1) >> 1);
  assign tick    = en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else begin
      cnt <= (cnt == div) ? '0 : cnt + 1'b1;
      if (tick)
        bclk <= 1'b0;
      else if (cnt == rise_at)
        bclk <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_frame_pos.sv
module aud_frame_pos
  import aud_ser_pkg::*;
#(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [POS_W-1:0] last_pos,
  output logic [POS_W-1:0] nxt_pos,
  output chan_e            nxt_chan,
  output logic             frame_start
);
  logic [POS_W-1:0] pos;
  chan_e            chan;
  logic             running;

  always_comb begin
    nxt_pos     = pos + 1'b1;
    nxt_chan    = chan;
    frame_start = 1'b0;
    if (!running) begin
      nxt_pos     = '0;
      nxt_chan    = CH_LEFT;
      frame_start = tick;
    end else if (pos == last_pos) begin
      nxt_pos     = '0;
      nxt_chan    = (chan == CH_LEFT) ? CH_RIGHT : CH_LEFT;
      frame_start = tick && (chan == CH_RIGHT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      chan    <= CH_LEFT;
      running <= 1'b0;
    end else if (!en) begin
      pos     <= '0;
      chan    <= CH_LEFT;
      running <= 1'b0;
    end else if (tick) begin
      pos     <= nxt_pos;
      chan    <= nxt_chan;
      running <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_in_hold.sv
module aud_in_hold #(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_left,
  input  logic [SMP_W-1:0] in_right,
  input  logic             take,      // a frame starts at this edge
  output logic [SMP_W-1:0] smp_left,  // pair in force for the bit being loaded
  output logic [SMP_W-1:0] smp_right,
  output logic             underrun
);
  logic [SMP_W-1:0] hold_l, hold_r, cur_l, cur_r;
  logic             full, fire, take_ok;

  assign in_ready  = !full;
  assign fire      = in_valid && !full;
  assign take_ok   = take && full;
  assign smp_left  = take_ok ? hold_l : cur_l;
  assign smp_right = take_ok ? hold_r : cur_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l   <= '0;
      hold_r   <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      full     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (fire) begin
        hold_l <= in_left;
        hold_r <= in_right;
        full   <= 1'b1;
      end else if (take_ok) begin
        full <= 1'b0;
      end
      if (take) begin
        cur_l <= smp_left;
        cur_r <= smp_right;
      end
      if (!en)
        underrun <= 1'b0;
      else if (take && !full)
        underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_bit_pick.sv
module aud_bit_pick
  import aud_ser_pkg::*;
#(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned POS_W = 8,
  parameter int unsigned CTL_W = 32,
  localparam int unsigned NB_W  = $clog2(SMP_W),
  localparam int unsigned CH_W  = CTL_W / 2,
  localparam int unsigned CL_W  = $clog2(CH_W)
) (
  input  logic [POS_W-1:0] pos,
  input  chan_e            chan,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  input  logic             lsb_first,
  input  logic [NB_W-1:0]  nbits_m1,
  input  logic             i2s_dly,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic [1:0]       ctl_en,
  input  logic [POS_W-1:0] ctl_pos,
  input  logic [CL_W-1:0]  ctl_len_m1,
  output logic             bit_o
);
  localparam int unsigned PW = POS_W + 1;

  logic [PW-1:0]    p, k, c;
  logic             in_data, in_ctl, ctl_on;
  logic [NB_W-1:0]  sidx;
  logic [CL_W-1:0]  cidx;
  logic [SMP_W-1:0] smp;
  logic [CH_W-1:0]  word;

  always_comb begin
    p       = {1'b0, pos};
    k       = p - PW'(i2s_dly);
    c       = p - {1'b0, ctl_pos};
    smp     = (chan == CH_RIGHT) ? smp_right : smp_left;
    word    = (chan == CH_RIGHT) ? ctl_word[CTL_W-1:CH_W] : ctl_word[CH_W-1:0];
    ctl_on  = (chan == CH_RIGHT) ? ctl_en[1] : ctl_en[0];
    in_data = (p >= PW'(i2s_dly)) && (k <= PW'(nbits_m1));
    in_ctl  = ctl_on && (p >= {1'b0, ctl_pos}) && (c <= PW'(ctl_len_m1));
    if (lsb_first)
      sidx = NB_W'(SMP_W - 1) - nbits_m1 + NB_W'(k);
    else
      sidx = NB_W'(SMP_W - 1) - NB_W'(k);
    cidx = ctl_len_m1 - CL_W'(c);
    if (in_data)
      bit_o = smp[sidx];
    else if (in_ctl)
      bit_o = word[cidx];
    else
      bit_o = 1'b0;
  end
endmodule

// File: rtl/aud_frame_ser.sv
module aud_frame_ser
  import aud_ser_pkg::*;
#(
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned BDIV_W = 7,
  parameter int unsigned LDIV_W = 8,
  parameter int unsigned CTL_W  = 32,
  localparam int unsigned NB_W  = $clog2(SMP_W),
  localparam int unsigned CL_W  = $clog2(CTL_W / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BDIV_W-1:0] bclk_div,
  input  logic [LDIV_W-1:0] lr_div,
  input  logic              lsb_first,
  input  logic [NB_W-1:0]   nbits_m1,
  input  logic              i2s_dly,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [1:0]        ctl_en,
  input  logic [LDIV_W-1:0] ctl_pos,
  input  logic [CL_W-1:0]   ctl_len_m1,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SMP_W-1:0]  in_left,
  input  logic [SMP_W-1:0]  in_right,
  output logic              bclk,
  output logic              lrclk,
  output logic              sdata,
  output logic              underrun
);
  logic              tick, frame_start, nxt_bit;
  logic [LDIV_W-1:0] nxt_pos;
  chan_e             nxt_chan;
  logic [SMP_W-1:0]  smp_l, smp_r;

  aud_bclk_gen #(.DIV_W(BDIV_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .en(en), .div(bclk_div),
    .tick(tick), .bclk(bclk)
  );

  aud_frame_pos #(.POS_W(LDIV_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .last_pos(lr_div),
    .nxt_pos(nxt_pos), .nxt_chan(nxt_chan), .frame_start(frame_start)
  );

  aud_in_hold #(.SMP_W(SMP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .take(frame_start), .smp_left(smp_l), .smp_right(smp_r),
    .underrun(underrun)
  );

  aud_bit_pick #(.SMP_W(SMP_W), .POS_W(LDIV_W), .CTL_W(CTL_W)) u_pick (
    .pos(nxt_pos), .chan(nxt_chan), .smp_left(smp_l), .smp_right(smp_r),
    .lsb_first(lsb_first), .nbits_m1(nbits_m1), .i2s_dly(i2s_dly),
    .ctl_word(ctl_word), .ctl_en(ctl_en), .ctl_pos(ctl_pos),
    .ctl_len_m1(ctl_len_m1), .bit_o(nxt_bit)
  );

  // Line registers: load only at a bit boundary, i.e. with the bclk fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrclk <= 1'b0;
      sdata <= 1'b0;
    end else if (!en) begin
      lrclk <= 1'b0;
      sdata <= 1'b0;
    end else if (tick) begin
      lrclk <= (nxt_chan == CH_RIGHT);
      sdata <= nxt_bit;
    end
  end
endmodule

// File: rtl/aud_frame_ser_chk.sv
module aud_frame_ser_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic bclk,
  input logic lrclk,
  input logic sdata,
  input logic in_valid,
  input logic in_ready,
  input logic underrun
);
  // R3: lines hold while the bit clock is high
  p_lines_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bclk |-> ($stable(sdata) && $stable(lrclk)));

  // R7: the slot fills on a handshake, so ready drops next cycle
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8: flag stays set while running
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && underrun) |=> underrun);

  // R8: flag clears when disabled
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !underrun);

  // R9: serial lines quiet when disabled
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk && !lrclk && !sdata));
endmodule

bind aud_frame_ser aud_frame_ser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bclk(bclk), .lrclk(lrclk),
  .sdata(sdata), .in_valid(in_valid), .in_ready(in_ready),
  .underrun(underrun)
);

// File: tb/tb_aud_frame_ser.sv
module tb_aud_frame_ser;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [6:0]  bclk_div = 7'd3;
  logic [7:0]  lr_div = 8'd31;
  logic        lsb_first = 1'b0;
  logic [3:0]  nbits_m1 = 4'd15;
  logic        i2s_dly = 1'b1;
  logic [31:0] ctl_word = '0;
  logic [1:0]  ctl_en = '0;
  logic [7:0]  ctl_pos = '0;
  logic [3:0]  ctl_len_m1 = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_left = '0, in_right = '0;
  logic        bclk, lrclk, sdata, underrun;

  aud_frame_ser dut (
    .clk(clk), .rst_n(rst_n), .en(en), .bclk_div(bclk_div), .lr_div(lr_div),
    .lsb_first(lsb_first), .nbits_m1(nbits_m1), .i2s_dly(i2s_dly),
    .ctl_word(ctl_word), .ctl_en(ctl_en), .ctl_pos(ctl_pos),
    .ctl_len_m1(ctl_len_m1), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .underrun(underrun)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] expq[$];          // scoreboard: pairs {left,right} in accept order
  logic [31:0] cur_exp = '0;
  logic [31:0] seed = 32'h1234_5678;
  int  pos_m = 0, last_rise = -1, cyc = 0, frames = 0;
  bit  mon_on = 1'b0;
  logic prev_bclk = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected line value from the layout rules (R4, R5, R6)
  function automatic bit exp_bit(input int p, input logic [31:0] s, output string tag);
    int  w  = int'(lr_div) + 1;
    bit  rt = (p >= w);
    int  q  = rt ? p - w : p;
    logic [15:0] v  = rt ? s[15:0] : s[31:16];
    logic [15:0] cw = rt ? ctl_word[31:16] : ctl_word[15:0];
    int  d  = int'(i2s_dly);
    int  nb = int'(nbits_m1) + 1;
    int  cl = int'(ctl_len_m1) + 1;
    int  cp = int'(ctl_pos);
    if (q >= d && q - d < nb) begin
      tag = (d != 0) ? "R5" : "R4";
      return lsb_first ? v[16 - nb + (q - d)] : v[15 - (q - d)];
    end
    tag = "R6";
    if (ctl_en[rt] && q >= cp && q - cp < cl) return cw[cl - 1 - (q - cp)];
    return 1'b0;
  endfunction

  // Monitor: compare each bit at the rising bit-clock edge
  always @(negedge clk) begin
    string tg;
    bit    eb;
    cyc++;
    if (mon_on && bclk && !prev_bclk) begin
      if (last_rise >= 0)
        chk((cyc - last_rise) == int'(bclk_div) + 1, "R1", "bclk period",
            cyc - last_rise, int'(bclk_div) + 1);
      last_rise = cyc;
      if (pos_m == 0) begin
        if (expq.size() > 0) cur_exp = expq.pop_front();  // else repeat (R8)
        frames++;
      end
      chk(lrclk == (pos_m > int'(lr_div)), "R2", "lrclk", lrclk, pos_m > int'(lr_div));
      eb = exp_bit(pos_m, cur_exp, tg);
      chk(sdata == eb, tg, $sformatf("sdata pos %0d pair %h", pos_m, cur_exp), sdata, eb);
      pos_m = (pos_m + 1) % (2 * (int'(lr_div) + 1));
    end
    prev_bclk = bclk;
  end

  function automatic logic [31:0] next_pair();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ {seed[15:0], seed[31:16]};
  endfunction

  // Driver: offer one pair, push to scoreboard at the accepting edge (R7)
  task automatic send(input logic [31:0] s);
    in_valid = 1'b1;
    {in_left, in_right} = s;
    forever begin
      if (in_ready) begin
        expq.push_back(s);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic run(input int nsend, input bit starve);
    int f0;
    pos_m = 0; last_rise = -1; mon_on = 1'b1;
    en = 1'b1;
    for (int i = 0; i < nsend; i++) send(next_pair());
    if (starve) begin
      f0 = frames;
      while (frames < f0 + 3) @(negedge clk);
      chk(underrun == 1'b1, "R8", "underrun after empty frame", underrun, 1);
      chk(in_ready == 1'b1, "R7", "ready while empty", in_ready, 1);
      send(next_pair());
      send(next_pair());
    end
    while (expq.size() > 1) @(negedge clk);
    chk(underrun == starve, "R8", "underrun state at end", underrun, starve);
    en = 1'b0;
    mon_on = 1'b0;
    @(negedge clk);
    chk(!bclk && !lrclk && !sdata, "R9", "lines idle", {bclk, lrclk, sdata}, 0);
    chk(underrun == 1'b0, "R8", "flag cleared by disable", underrun, 0);
    chk(in_ready == 1'b0, "R7", "slot still holds pair", in_ready, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bclk && !lrclk && !sdata, "R10", "lines in reset", {bclk, lrclk, sdata}, 0);
    chk(underrun == 1'b0, "R10", "flag in reset", underrun, 0);
    chk(in_ready == 1'b1, "R10", "ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    send(next_pair());                       // preload slot before enabling
    chk(in_ready == 1'b0, "R7", "ready low after handshake", in_ready, 0);
    // A: 64-bit frame, 16 bits MSB first, one-bit delay, divide by 4
    run(5, 1'b0);
    // B: odd divide, 12 bits LSB first, overlapping control words, starvation
    bclk_div = 7'd2; lr_div = 8'd15; lsb_first = 1'b1; nbits_m1 = 4'd11;
    i2s_dly = 1'b0; ctl_word = 32'hA5C3_6E19; ctl_en = 2'b11;
    ctl_pos = 8'd10; ctl_len_m1 = 4'd3;
    run(3, 1'b1);
    // C: 512-bit frame, single data bit, control word on right half only
    bclk_div = 7'd1; lr_div = 8'd255; lsb_first = 1'b0; nbits_m1 = 4'd0;
    i2s_dly = 1'b1; ctl_word = 32'hB7D1_FFFF; ctl_en = 2'b10;
    ctl_pos = 8'd200; ctl_len_m1 = 4'd15;
    run(3, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 200000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule